// File: doc/BRIEF.md
# GPIO Interrupt Trigger Unit

This block watches a bank of already-synchronized GPIO input levels and turns pin activity into latched interrupt events. For every pin, two mode bits select the condition that counts as an event: a trigger-select bit picks edge or level sensing, and an invert bit picks the polarity. Events are held in status words of 32 bits that software clears by writing ones. A matching set of enable words masks them. Every enabled pending bit is ORed into one registered interrupt line.

Address decoding is done by the surrounding pin register bank. This unit only sees per-word write strobes and a shared write data bus, and it drives its status and enable words back for readout. Pin n lives in word n/32 at bit n%32. In the flat output vectors that is bit n.

Top module: `gpio_irq_trig`

## Requirements
- R1: With trigger-select 0 and invert 0, a pin whose level goes from 0 to 1 between two consecutive clock edges sets its status bit at the second edge.
- R2: With trigger-select 0 and invert 1, a 1-to-0 transition sets the status bit and a 0-to-1 transition does not.
- R3: With trigger-select 1, the status bit is set at every edge where the pin equals the invert bit. Invert 0 means active low and invert 1 means active high.
- R4: Edge sensing compares the pin with its level at the previous clock edge. At the first edge after reset release, no edge event is reported, whatever the pin level.
- R5: A status write to word w clears each bit where the write data is 1 and leaves each bit where it is 0 unchanged.
- R6: If an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R7: While a level-mode pin stays active, clearing its status bit has no lasting effect. The bit reads 1 again after the write.
- R8: An enable write to word w replaces that word with the write data. Bits for pins at or above NPIN always read 0 in both status and enable.
- R9: The interrupt output is a registered OR of (status AND enable). It rises one edge after an enabled status bit is set and stays 0 while the only set status bits are masked.
- R10: After reset, every status bit, every enable bit and the interrupt output are 0.
- R11: Pin n maps to word n/32, bit n%32, which is written through strobe bit n/32 and read at flat bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPIN | Synchronized pin levels |
| trig_lvl | input | NPIN | Per-pin trigger select: 0 edge, 1 level |
| trig_inv | input | NPIN | Per-pin polarity invert |
| sts_we | input | NW | Per-word strobe: write-one-to-clear status |
| en_we | input | NW | Per-word strobe: replace enable word |
| wdata | input | WORD_W | Shared write data |
| sts_word | output | NW*WORD_W | Status words, flat, pin n at bit n |
| en_word | output | NW*WORD_W | Enable words, flat |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench drives each of the four mode encodings against short pin waveforms that contain both transitions, so it can tell an edge detector that is wired to the wrong polarity or that treats levels as edges. It then targets the following corner cases, each with the failure it exposes:
- A pin held high through reset, to expose a detector that reports a spurious edge from the reset value.
- A clearing write that lands on the same edge as a new rising edge, which a design giving the clear priority would lose.
- A level-mode pin held active, which must re-set its bit right after it is cleared.
- A write of zeros to a status word, which a plain overwrite would wrongly clear.
- The interrupt line checked one cycle late and with the enable removed, exposing a combinational or unmasked output.

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig #(
  parameter int NPIN   = 40,
  parameter int WORD_W = 32,
  localparam int NW    = (NPIN + WORD_W - 1) / WORD_W,
  localparam int PADW  = NW * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic [NPIN-1:0]   trig_lvl,
  input  logic [NPIN-1:0]   trig_inv,
  input  logic [NW-1:0]     sts_we,
  input  logic [NW-1:0]     en_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [PADW-1:0]   sts_word,
  output logic [PADW-1:0]   en_word,
  output logic              irq
);

  logic [NPIN-1:0] prev_q, rise, fall, evt;
  logic            primed_q;
  logic [PADW-1:0] valid, evt_pad, clr, en_nxt, sts_q, en_q;
  logic            irq_q;

  genvar gi;
  generate
    for (gi = 0; gi < PADW; gi++) begin : g_valid
      assign valid[gi] = (gi < NPIN);
    end
  endgenerate

  assign rise = pin_lvl & ~prev_q & {NPIN{primed_q}};
  assign fall = ~pin_lvl & prev_q & {NPIN{primed_q}};
  assign evt  = (trig_lvl & ~(pin_lvl ^ trig_inv))
              | (~trig_lvl & ~trig_inv & rise)
              | (~trig_lvl &  trig_inv & fall);

  always_comb begin
    evt_pad = '0;
    evt_pad[NPIN-1:0] = evt;
    clr    = '0;
    en_nxt = en_q;
    for (int w = 0; w < NW; w++) begin
      if (sts_we[w]) clr[w*WORD_W +: WORD_W] = wdata;
      if (en_we[w])  en_nxt[w*WORD_W +: WORD_W] = wdata;
    end
    en_nxt = en_nxt & valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      sts_q    <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      prev_q   <= pin_lvl;
      primed_q <= 1'b1;
      sts_q    <= ((sts_q & ~clr) | evt_pad) & valid;
      en_q     <= en_nxt;
      irq_q    <= |(sts_q & en_q);
    end
  end

  assign sts_word = sts_q;
  assign en_word  = en_q;
  assign irq      = irq_q;

  // R5
  sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sts_q & $past(sts_q) & ~$past(clr)) == '0));

  // R3
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((sts_q[NPIN-1:0] & $past(trig_lvl & ~(pin_lvl ^ trig_inv)))
                      == $past(trig_lvl & ~(pin_lvl ^ trig_inv))));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q)) |=> irq);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_q & en_q)) |=> !irq);

  generate
    for (gi = 0; gi < NW; gi++) begin : g_en_chk
      // R8
      en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_we[gi]) |-> $stable(en_q[gi*WORD_W +: WORD_W]));
    end
  endgenerate

endmodule

// File: tb/gpio_irq_trig_test.sv
module gpio_irq_trig_test;
  localparam int NPIN = 40;
  localparam int NW   = 2;
  localparam int TP   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIN-1:0] pin_lvl = '0, trig_lvl = '0, trig_inv = '0;
  logic [NW-1:0] sts_we = '0, en_we = '0;
  logic [31:0] wdata = '0;
  logic [63:0] sts_word, en_word;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_trig #(.NPIN(NPIN), .WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_lvl(trig_lvl),
    .trig_inv(trig_inv), .sts_we(sts_we), .en_we(en_we), .wdata(wdata),
    .sts_word(sts_word), .en_word(en_word), .irq(irq));

  // {trig_sel, invert, wave[3:0] (bit3 applied first), expected status}
  localparam logic [6:0] VEC [12] = '{
    {2'b00, 4'b0001, 1'b1},
    {2'b00, 4'b1110, 1'b0},
    {2'b01, 4'b1110, 1'b1},
    {2'b01, 4'b0111, 1'b0},
    {2'b10, 4'b1111, 1'b0},
    {2'b10, 4'b1101, 1'b1},
    {2'b11, 4'b0000, 1'b0},
    {2'b11, 4'b0010, 1'b1},
    {2'b00, 4'b1010, 1'b1},
    {2'b01, 4'b0101, 1'b1},
    {2'b00, 4'b0000, 1'b0},
    {2'b01, 4'b1111, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_lvl[3] = 1'b1;
    nclk(3);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 status", sts_word, 64'h0);
    chk("R10 enable", en_word, 64'h0);
    chk("R10 irq", {63'h0, irq}, 64'h0);
    nclk(3);
    // R4 pin high through reset gives no edge
    chk("R4 no edge after reset", sts_word, 64'h0);
    pin_lvl[3] = 1'b0;
    nclk(2);

    // R1 R2 R3 mode table
    for (int v = 0; v < 12; v++) begin
      trig_lvl[TP] = VEC[v][6];
      trig_inv[TP] = VEC[v][5];
      pin_lvl[TP]  = VEC[v][4];
      nclk(2);
      sts_we = 2'b01; wdata = 32'hFFFF_FFFF;
      nclk(1);
      sts_we = '0; pin_lvl[TP] = VEC[v][3];
      nclk(1);
      pin_lvl[TP] = VEC[v][2];
      nclk(1);
      pin_lvl[TP] = VEC[v][1];
      nclk(1);
      chk($sformatf("R1/R2/R3 vector %0d", v), sts_word, {63'h0, VEC[v][0]} << TP);
      pin_lvl[TP] = 1'b0; trig_lvl[TP] = 1'b0; trig_inv[TP] = 1'b0;
    end
    nclk(2);
    sts_we = 2'b01; wdata = 32'hFFFF_FFFF;
    nclk(1);
    sts_we = '0;
    chk("R9 no irq with enables 0", {63'h0, irq}, 64'h0);

    // R8 enable write and unused bits
    en_we = 2'b10; wdata = 32'hFFFF_FFFF;
    nclk(1);
    chk("R8 unused enable bits", en_word, 64'h0000_00FF_0000_0000);
    wdata = 32'h2;
    nclk(1);
    en_we = '0;
    chk("R8 enable replace", en_word, 64'h0000_0002_0000_0000);

    // R11 R1 R9 pin 33 rising edge
    pin_lvl[33] = 1'b1;
    nclk(1);
    chk("R11 pin33 at bit33", sts_word, 64'h1 << 33);
    chk("R9 irq not yet", {63'h0, irq}, 64'h0);
    nclk(1);
    chk("R9 irq one cycle later", {63'h0, irq}, 64'h1);

    // R5 write of zero keeps bit
    sts_we = 2'b10; wdata = 32'h0;
    nclk(1);
    sts_we = '0;
    chk("R5 zero write keeps", sts_word, 64'h1 << 33);

    // R5 write of one clears
    sts_we = 2'b10; wdata = 32'h2;
    nclk(1);
    sts_we = '0;
    chk("R5 one write clears", sts_word, 64'h0);
    chk("R9 irq still registered", {63'h0, irq}, 64'h1);
    nclk(1);
    chk("R9 irq drops", {63'h0, irq}, 64'h0);

    // R6 event and clear on same edge
    pin_lvl[33] = 1'b0;
    nclk(1);
    pin_lvl[33] = 1'b1; sts_we = 2'b10; wdata = 32'h2;
    nclk(1);
    sts_we = '0;
    chk("R6 event beats clear", sts_word, 64'h1 << 33);

    // R9 masked status gives no irq
    en_we = 2'b10; sts_we = 2'b10; wdata = 32'h0;
    nclk(1);
    en_we = '0; sts_we = 2'b10; wdata = 32'hFFFF_FFFF;
    nclk(1);
    sts_we = '0;
    pin_lvl[33] = 1'b0;
    nclk(1);
    pin_lvl[33] = 1'b1;
    nclk(1);
    chk("R9 masked status set", sts_word, 64'h1 << 33);
    nclk(2);
    chk("R9 masked no irq", {63'h0, irq}, 64'h0);

    // R7 level-high pin keeps re-setting
    sts_we = 2'b10; wdata = 32'hFFFF_FFFF;
    nclk(1);
    sts_we = '0;
    trig_lvl[34] = 1'b1; trig_inv[34] = 1'b1; pin_lvl[34] = 1'b1;
    nclk(1);
    chk("R3 level high sets", sts_word, 64'h1 << 34);
    sts_we = 2'b10; wdata = 32'h4;
    nclk(1);
    sts_we = '0;
    chk("R7 clear has no lasting effect", sts_word, 64'h1 << 34);
    pin_lvl[34] = 1'b0;
    nclk(1);
    sts_we = 2'b10; wdata = 32'h4;
    nclk(1);
    sts_we = '0;
    chk("R7 clears once inactive", sts_word, 64'h0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule